// File: doc/BRIEF.md
# Segmented Nibble Accumulator Processor

This block is a compact 4-bit processor. It has a single accumulator, four general registers reached through a separately loaded register-select latch, three compare flags, a 4-bit input port and a 4-bit output latch. Its program store holds 256 eight-bit words and sits inside the block. An external loader fills the store through a write port. Each word carries an operation code in its upper nibble and a data nibble in its lower nibble.

The program store is split into sixteen pages of sixteen words. A page register supplies the upper four address bits and a 4-bit program counter supplies the lower four. Execution therefore circles within one page. The only way to move to another page is a conditional branch that takes a taken flag, copies the accumulator into the page register and restarts at word 0 of that page. A level-sensitive `run` input lets the core step through instructions. When `run` is low the core parks and holds all of its state.

The sequencer has three named states. HALT is the parked state. FETCH latches the addressed program word. EXEC carries out that word. The transitions are as follows:
- HALT→FETCH when `run` is high.
- FETCH→EXEC when `run` is high.
- FETCH→HALT when `run` is low.
- EXEC→FETCH when `run` is high.
- EXEC→HALT when `run` is low.
- Any state goes to HALT on reset.

Every instruction costs one FETCH cycle and one EXEC cycle.

Top module: `nibble_seg_cpu`

## Requirements
- R1: A synchronous `rst` clears the accumulator, output latch, flags, page, program counter, register-select latch and all four registers, and puts the sequencer in HALT.
- R2: The sequencer follows HALT→FETCH→EXEC→FETCH while `run` is high. It enters HALT from FETCH or EXEC when `run` is low. In HALT with `run` low, no architectural state changes, whatever `in_port` does.
- R3: A program word has its opcode in bits [7:4] and its data in bits [3:0]. It is fetched from address {page, pc}. When `ld_we` is high, a clock edge writes `ld_data` to `ld_addr`.
- R4: Opcode 1 loads the data nibble into the accumulator. Opcode 13 loads `in_port` into the accumulator.
- R5: Opcode 4 adds one to the accumulator and opcode 5 subtracts one. Both wrap modulo 16, and neither touches the flags.
- R6: Opcode 6 copies the accumulator into the register-select latch. Opcode 3 writes the accumulator into the register chosen by the latch's low two bits. Opcode 2 reads that register into the accumulator.
- R7: Opcode 7 compares the accumulator with the data nibble, and opcode 8 compares it with the selected register. Each sets exactly one flag in `flags_o`: bit 0 for less, bit 1 for equal, bit 2 for greater. No other instruction changes the flags.
- R8: Opcodes 10, 11 and 12 test the less, equal and greater flag respectively. If the tested flag is set, the accumulator moves into the page register and pc becomes 0. If it is clear, the instruction acts as a no-op.
- R9: Every other instruction advances pc by one modulo 16 and leaves the page unchanged.
- R10: Opcode 9 sets pc to 0 and keeps the current page.
- R11: Opcode 14 copies the accumulator to `out_port`. The latch holds its value until the next opcode 14.
- R12: Opcode 15 and the reserved opcode 0 change nothing except pc.
- R13: Suppose a loader write lands on the same edge as a FETCH of the same address. The fetch captures the old word, and later fetches see the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Execute enable; low parks the core in HALT |
| ld_we | input | 1 | Program store write enable |
| ld_addr | input | 8 | Program store write address {page, word} |
| ld_data | input | 8 | Program word to write |
| in_port | input | 4 | Value read by the input instruction |
| out_port | output | 4 | Output latch |
| acc_o | output | 4 | Accumulator |
| flags_o | output | 3 | {greater, equal, less} |
| seg_o | output | 4 | Current page |
| pc_o | output | 4 | Program counter |

## Verification
The loader write port and the instruction fetch can act on the same program word at the same clock edge. The bench provokes this by raising `ld_we` during the FETCH cycle and aiming it at the very word being fetched. It then judges the result twice. First, the executed instruction must be the old word. Second, after a pc reset, the same address must yield the new word. A second overlap arises when a not-taken branch advances the program counter at the same time as a branch on another flag would redirect it. Branch tests with each flag set and clear confirm that only the matching flag redirects.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
    localparam int NIB    = 4;
    localparam int WORD_W = 2 * NIB;
    localparam int FLAG_W = 3;
    localparam int F_LT   = 0;
    localparam int F_EQ   = 1;
    localparam int F_GT   = 2;

    typedef enum logic [3:0] {
        OP_RSVD  = 4'd0,
        OP_LIT   = 4'd1,
        OP_LOAD  = 4'd2,
        OP_STORE = 4'd3,
        OP_INC   = 4'd4,
        OP_DEC   = 4'd5,
        OP_SEL   = 4'd6,
        OP_CMPL  = 4'd7,
        OP_CMPR  = 4'd8,
        OP_PCCLR = 4'd9,
        OP_BRLT  = 4'd10,
        OP_BREQ  = 4'd11,
        OP_BRGT  = 4'd12,
        OP_IN    = 4'd13,
        OP_OUT   = 4'd14,
        OP_NOP   = 4'd15
    } opcode_e;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } state_e;
endpackage

// File: rtl/nsc_progmem.sv
module nsc_progmem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write at the edge; read is combinational, so a same-edge fetch sees the old word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nsc_regfile.sv
module nsc_regfile #(
    parameter int W    = 4,
    parameter int NREG = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] sel,
    input  logic [W-1:0]            wdata,
    output logic [W-1:0]            rdata
);
    logic [NREG-1:0][W-1:0] rd_vec;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                      q <= '0;
            else if (we && sel == i[$clog2(NREG)-1:0]) q <= wdata;
        end
        assign rd_vec[i] = q;
    end

    assign rdata = rd_vec[sel];
endmodule

// File: rtl/nsc_cmp.sv
module nsc_cmp
    import nsc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    output logic [FLAG_W-1:0] flags
);
    always_comb begin
        flags       = '0;
        flags[F_LT] = (a < b);
        flags[F_EQ] = (a == b);
        flags[F_GT] = (a > b);
    end
endmodule

// File: rtl/nibble_seg_cpu.sv
module nibble_seg_cpu
    import nsc_pkg::*;
#(
    parameter int NIB_W = NIB,
    parameter int NREG  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 ld_we,
    input  logic [2*NIB_W-1:0]   ld_addr,
    input  logic [2*NIB_W-1:0]   ld_data,
    input  logic [NIB_W-1:0]     in_port,
    output logic [NIB_W-1:0]     out_port,
    output logic [NIB_W-1:0]     acc_o,
    output logic [FLAG_W-1:0]    flags_o,
    output logic [NIB_W-1:0]     seg_o,
    output logic [NIB_W-1:0]     pc_o
);
    localparam int IW     = 2 * NIB_W;
    localparam int PAW    = 2 * NIB_W;
    localparam int RSEL_W = $clog2(NREG);

    state_e              state_q, state_d;
    logic [IW-1:0]       ir_q;
    logic [NIB_W-1:0]    acc_q, out_q, seg_q, pc_q;
    logic [RSEL_W-1:0]   rsel_q;
    logic [FLAG_W-1:0]   flags_q;

    opcode_e             op;
    logic [NIB_W-1:0]    dat;
    logic [IW-1:0]       pm_rdata;
    logic [NIB_W-1:0]    rf_rdata;
    logic [NIB_W-1:0]    cmp_b;
    logic [FLAG_W-1:0]   cmp_flags;
    logic                rf_we;
    logic                is_exec;

    assign op      = opcode_e'(ir_q[IW-1 -: NIB_W]);
    assign dat     = ir_q[NIB_W-1:0];
    assign is_exec = (state_q == ST_EXEC);
    assign rf_we   = is_exec && (op == OP_STORE);
    assign cmp_b   = (op == OP_CMPR) ? rf_rdata : dat;

    nsc_progmem #(.AW(PAW), .DW(IW)) u_pm (
        .clk   (clk),
        .we    (ld_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr ({seg_q, pc_q}),
        .rdata (pm_rdata)
    );

    nsc_regfile #(.W(NIB_W), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .sel   (rsel_q),
        .wdata (acc_q),
        .rdata (rf_rdata)
    );

    nsc_cmp #(.W(NIB_W)) u_cmp (
        .a     (acc_q),
        .b     (cmp_b),
        .flags (cmp_flags)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (run) state_d = ST_FETCH;
            ST_FETCH: state_d = run ? ST_EXEC  : ST_HALT;
            ST_EXEC:  state_d = run ? ST_FETCH : ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HALT;
        else     state_q <= state_d;
    end

    // Datapath registers driven by the current state
    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q    <= '0;
            acc_q   <= '0;
            out_q   <= '0;
            seg_q   <= '0;
            pc_q    <= '0;
            rsel_q  <= '0;
            flags_q <= '0;
        end else begin
            unique case (state_q)
                ST_FETCH: if (run) ir_q <= pm_rdata;
                ST_EXEC: begin
                    pc_q <= pc_q + 1'b1;
                    unique case (op)
                        OP_LIT:   acc_q   <= dat;
                        OP_LOAD:  acc_q   <= rf_rdata;
                        OP_STORE: ;
                        OP_INC:   acc_q   <= acc_q + 1'b1;
                        OP_DEC:   acc_q   <= acc_q - 1'b1;
                        OP_SEL:   rsel_q  <= acc_q[RSEL_W-1:0];
                        OP_CMPL:  flags_q <= cmp_flags;
                        OP_CMPR:  flags_q <= cmp_flags;
                        OP_PCCLR: pc_q    <= '0;
                        OP_BRLT:  if (flags_q[F_LT]) begin seg_q <= acc_q; pc_q <= '0; end
                        OP_BREQ:  if (flags_q[F_EQ]) begin seg_q <= acc_q; pc_q <= '0; end
                        OP_BRGT:  if (flags_q[F_GT]) begin seg_q <= acc_q; pc_q <= '0; end
                        OP_IN:    acc_q   <= in_port;
                        OP_OUT:   out_q   <= acc_q;
                        OP_RSVD:  ;
                        OP_NOP:   ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    assign out_port = out_q;
    assign acc_o    = acc_q;
    assign flags_o  = flags_q;
    assign seg_o    = seg_q;
    assign pc_o     = pc_q;

    // R1
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && pc_q == '0 && seg_q == '0 && flags_q == '0
                 && out_q == '0 && state_q == ST_HALT));

    // R2
    p_halt_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT && !run) |=>
            ($stable(acc_q) && $stable(pc_q) && $stable(seg_q) && $stable(out_q) && $stable(flags_q)));

    // R5
    p_inc_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (is_exec && op == OP_INC) |=> (acc_q == $past(acc_q) + 1'b1 && $stable(flags_q)));

    // R7
    p_flags_onehot0_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags_q));

    p_cmp_sets_one_r7: assert property (@(posedge clk) disable iff (rst)
        (is_exec && (op == OP_CMPL || op == OP_CMPR)) |=> ($countones(flags_q) == 1));

    // R8
    p_branch_taken_r8: assert property (@(posedge clk) disable iff (rst)
        (is_exec && op == OP_BREQ && flags_q[F_EQ]) |=> (pc_q == '0 && seg_q == $past(acc_q)));

    // R9
    p_pc_step_r9: assert property (@(posedge clk) disable iff (rst)
        (is_exec && op != OP_PCCLR && op != OP_BRLT && op != OP_BREQ && op != OP_BRGT)
            |=> (pc_q == $past(pc_q) + 1'b1 && $stable(seg_q)));

    // R11
    p_out_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(is_exec && op == OP_OUT) |=> $stable(out_q));
endmodule

// File: tb/nibble_seg_cpu_test.sv
module nibble_seg_cpu_test;
    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       run = 1'b0;
    logic       ld_we = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [3:0] in_port = '0;
    logic [3:0] out_port, acc_o, seg_o, pc_o;
    logic [2:0] flags_o;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    nibble_seg_cpu uut (
        .clk(clk), .rst(rst), .run(run), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .in_port(in_port), .out_port(out_port), .acc_o(acc_o),
        .flags_o(flags_o), .seg_o(seg_o), .pc_o(pc_o)
    );

    function automatic logic [7:0] w(input logic [3:0] op, input logic [3:0] d);
        return {op, d};
    endfunction

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Executes exactly n instructions from HALT and parks again.
    task automatic run_instrs(input int n);
        @(negedge clk);
        run = 1'b1;
        repeat (1 + 2 * n) @(posedge clk);
        @(negedge clk);
        run = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "acc", {4'h0, acc_o}, 8'h00);
        check("R1", "out", {4'h0, out_port}, 8'h00);
        check("R1", "flags", {5'h0, flags_o}, 8'h00);
        check("R1", "seg", {4'h0, seg_o}, 8'h00);
        check("R1", "pc", {4'h0, pc_o}, 8'h00);
    endtask

    task automatic t_arith();
        do_reset();
        put(8'h00, w(1, 4'h2));
        put(8'h01, w(7, 4'h9));
        put(8'h02, w(1, 4'hF));
        put(8'h03, w(4, 4'h0));
        put(8'h04, w(5, 4'h0));
        put(8'h05, w(5, 4'h0));
        put(8'h06, w(14, 4'h0));
        run_instrs(3);
        check("R4", "acc after LIT F", {4'h0, acc_o}, 8'h0F);
        check("R3", "pc after 3", {4'h0, pc_o}, 8'h03);
        run_instrs(1);
        check("R5", "INC wrap", {4'h0, acc_o}, 8'h00);
        check("R5", "flags kept by INC", {5'h0, flags_o}, 8'h01);
        run_instrs(1);
        check("R5", "DEC wrap", {4'h0, acc_o}, 8'h0F);
        run_instrs(2);
        check("R5", "DEC result", {4'h0, acc_o}, 8'h0E);
        check("R11", "out", {4'h0, out_port}, 8'h0E);
        check("R5", "flags kept by DEC", {5'h0, flags_o}, 8'h01);
        // R2: parked core ignores input activity
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_port = 4'(i * 5);
        end
        check("R2", "acc held in HALT", {4'h0, acc_o}, 8'h0E);
        check("R2", "pc held in HALT", {4'h0, pc_o}, 8'h07);
    endtask

    task automatic t_regs();
        do_reset();
        put(8'h00, w(1, 4'h5));
        put(8'h01, w(6, 4'h0));
        put(8'h02, w(1, 4'h9));
        put(8'h03, w(3, 4'h0));
        put(8'h04, w(1, 4'h1));
        put(8'h05, w(6, 4'h0));
        put(8'h06, w(1, 4'h0));
        put(8'h07, w(2, 4'h0));
        put(8'h08, w(14, 4'h0));
        put(8'h09, w(1, 4'h2));
        put(8'h0A, w(6, 4'h0));
        put(8'h0B, w(2, 4'h0));
        run_instrs(9);
        check("R6", "load aliased reg", {4'h0, acc_o}, 8'h09);
        check("R6", "out of reg", {4'h0, out_port}, 8'h09);
        run_instrs(3);
        check("R6", "untouched reg", {4'h0, acc_o}, 8'h00);
        check("R11", "out held", {4'h0, out_port}, 8'h09);
    endtask

    task automatic t_cmp();
        do_reset();
        put(8'h00, w(1, 4'h6));
        put(8'h01, w(7, 4'h9));
        put(8'h02, w(7, 4'h6));
        put(8'h03, w(7, 4'h2));
        put(8'h04, w(1, 4'h3));
        put(8'h05, w(6, 4'h0));
        put(8'h06, w(1, 4'h7));
        put(8'h07, w(3, 4'h0));
        put(8'h08, w(1, 4'h7));
        put(8'h09, w(8, 4'h0));
        put(8'h0A, w(4, 4'h0));
        put(8'h0B, w(8, 4'h0));
        put(8'h0C, w(1, 4'h1));
        put(8'h0D, w(8, 4'h0));
        run_instrs(2);
        check("R7", "CMPL less", {5'h0, flags_o}, 8'h01);
        run_instrs(1);
        check("R7", "CMPL equal", {5'h0, flags_o}, 8'h02);
        run_instrs(1);
        check("R7", "CMPL greater", {5'h0, flags_o}, 8'h04);
        run_instrs(6);
        check("R7", "CMPR equal", {5'h0, flags_o}, 8'h02);
        run_instrs(2);
        check("R7", "CMPR greater", {5'h0, flags_o}, 8'h04);
        run_instrs(2);
        check("R7", "CMPR less", {5'h0, flags_o}, 8'h01);
    endtask

    task automatic t_branch();
        do_reset();
        put(8'h00, w(1, 4'h3));
        put(8'h01, w(7, 4'h5));
        put(8'h02, w(1, 4'h2));
        put(8'h03, w(12, 4'h0));
        put(8'h04, w(11, 4'h0));
        put(8'h05, w(10, 4'h0));
        put(8'h20, w(1, 4'hA));
        put(8'h21, w(14, 4'h0));
        put(8'h22, w(7, 4'hA));
        put(8'h23, w(1, 4'h5));
        put(8'h24, w(11, 4'h0));
        put(8'h50, w(7, 4'h1));
        put(8'h51, w(1, 4'h0));
        put(8'h52, w(12, 4'h0));
        run_instrs(4);
        check("R8", "greater-branch not taken pc", {4'h0, pc_o}, 8'h04);
        check("R8", "greater-branch not taken seg", {4'h0, seg_o}, 8'h00);
        run_instrs(1);
        check("R8", "equal-branch not taken pc", {4'h0, pc_o}, 8'h05);
        run_instrs(1);
        check("R8", "less-branch taken seg", {4'h0, seg_o}, 8'h02);
        check("R8", "less-branch taken pc", {4'h0, pc_o}, 8'h00);
        run_instrs(2);
        check("R8", "runs in new page", {4'h0, out_port}, 8'h0A);
        check("R9", "pc in new page", {4'h0, pc_o}, 8'h02);
        run_instrs(3);
        check("R8", "equal-branch taken seg", {4'h0, seg_o}, 8'h05);
        run_instrs(3);
        check("R8", "greater-branch taken seg", {4'h0, seg_o}, 8'h00);
        check("R8", "greater-branch taken pc", {4'h0, pc_o}, 8'h00);
    endtask

    task automatic t_pcclr();
        do_reset();
        put(8'h00, w(1, 4'h7));
        put(8'h01, w(7, 4'h7));
        put(8'h02, w(11, 4'h0));
        put(8'h70, w(1, 4'h4));
        put(8'h71, w(4, 4'h0));
        put(8'h72, w(9, 4'h0));
        run_instrs(3);
        check("R8", "into page 7", {4'h0, seg_o}, 8'h07);
        run_instrs(3);
        check("R10", "pc cleared", {4'h0, pc_o}, 8'h00);
        check("R10", "page kept", {4'h0, seg_o}, 8'h07);
        check("R10", "acc", {4'h0, acc_o}, 8'h05);
        run_instrs(2);
        check("R10", "re-executes page start", {4'h0, pc_o}, 8'h02);
    endtask

    task automatic t_io();
        do_reset();
        put(8'h00, w(13, 4'h0));
        put(8'h01, w(14, 4'h0));
        put(8'h02, w(1, 4'h1));
        put(8'h03, w(13, 4'h0));
        in_port = 4'hB;
        run_instrs(2);
        check("R4", "IN", {4'h0, acc_o}, 8'h0B);
        check("R11", "OUT", {4'h0, out_port}, 8'h0B);
        in_port = 4'h3;
        run_instrs(1);
        check("R11", "out holds after LIT", {4'h0, out_port}, 8'h0B);
        run_instrs(1);
        check("R4", "IN new value", {4'h0, acc_o}, 8'h03);
    endtask

    task automatic t_nop();
        do_reset();
        put(8'h00, w(1, 4'h6));
        put(8'h01, w(7, 4'h6));
        put(8'h02, w(14, 4'h0));
        put(8'h03, w(0, 4'h7));
        put(8'h04, w(15, 4'h3));
        for (int a = 5; a < 16; a++) put(8'(a), w(15, 4'h0));
        run_instrs(3);
        run_instrs(2);
        check("R12", "acc unchanged", {4'h0, acc_o}, 8'h06);
        check("R12", "flags unchanged", {5'h0, flags_o}, 8'h02);
        check("R12", "out unchanged", {4'h0, out_port}, 8'h06);
        check("R12", "pc advanced", {4'h0, pc_o}, 8'h05);
        run_instrs(11);
        check("R9", "pc wraps in page", {4'h0, pc_o}, 8'h00);
        check("R9", "page unchanged on wrap", {4'h0, seg_o}, 8'h00);
    endtask

    task automatic t_collide();
        do_reset();
        put(8'h00, w(1, 4'h3));
        put(8'h01, w(9, 4'h0));
        @(negedge clk);
        run = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = 8'h00; ld_data = w(1, 4'h9);
        @(posedge clk);
        @(negedge clk);
        ld_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
        run = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R13", "fetch sees old word", {4'h0, acc_o}, 8'h03);
        run_instrs(1);
        run_instrs(1);
        check("R13", "later fetch sees new word", {4'h0, acc_o}, 8'h09);
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_arith();
        t_regs();
        t_cmp();
        t_branch();
        t_pcclr();
        t_io();
        t_nop();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule